// File: doc/BRIEF.md
# Interrupt Control Register File with Delegation Windows

This block holds the interrupt state of a processor hart behind a simple register access port: the machine-level pending, enable and delegation words, a supervisor trap vector, a pair of host mailbox words and a software-interrupt doorbell. Each access presents a 12-bit address, write data and read and write strobes. Every register applies its own writable-bit mask, so bits the hardware does not implement, or that software may not change, keep their value whatever is written.

The supervisor pending and enable registers have no storage of their own. They are windows onto the machine words. A read returns only the bits the delegation word hands to the supervisor. A write reaches only bits that are both delegated and writable in the machine word behind the window. The host-to-processor mailbox drives the host interrupt pending bit. The doorbell address sets or clears the machine software pending bit from data bit 0.

Read data is registered and appears one cycle after the read strobe. An access to an address the block does not decode changes no state and raises a one-cycle illegal-access pulse. Interrupt bit positions used throughout: supervisor software 1, machine software 3, supervisor timer 5, machine timer 7, host 9, coprocessor 10.

Top module: `csr_irq_file`

## Requirements
- R1: After reset every register reads 0 and `csr_illegal_o` is low.
- R2: Machine pending (address 0x344) accepts writes only to bits 1, 3 and 5 (mask 0x0000002A). All other bits, including the host bit 9, keep their value.
- R3: Machine enable (address 0x304) accepts writes only to bits 1, 3, 5, 7, 9 and 10 (mask 0x000006AA).
- R4: Delegation (address 0x303) accepts writes only to bits 1, 5, 9 and 10 (mask 0x00000622).
- R5: A read of supervisor pending (0x144) or supervisor enable (0x104) returns the machine word ANDed with the delegation word.
- R6: A write to supervisor pending or supervisor enable changes only the bits that are set in the delegation word and also writable under the machine word's mask (R2 or R3). The machine word's other bits are unchanged.
- R7: A write to the supervisor trap vector (0x105) stores the data with bits 1:0 forced to 0.
- R8: A write to the to-host mailbox (0x780) takes effect only while that word is 0. Otherwise it is ignored, and this includes writes of 0.
- R9: A write to the from-host mailbox (0x781) stores the data. It sets host pending bit 9 when the data is nonzero and clears that bit when the data is zero.
- R10: A write to the doorbell (0x783) copies data bit 0 into machine pending bit 3. A read of the doorbell returns 0.
- R11: A read or write of any other address raises `csr_illegal_o` for exactly the next cycle and changes no register. Accesses to decoded addresses never raise it.
- R12: `csr_rdata_o` shows the addressed value one cycle after a decoded read strobe and holds until the next decoded read. A read issued in the same cycle as a write to the same address returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | XLEN | Write data |
| csr_we_i | input | 1 | Write strobe |
| csr_re_i | input | 1 | Read strobe |
| csr_rdata_o | output | XLEN | Registered read data |
| csr_illegal_o | output | 1 | One-cycle pulse after an access to an undecoded address |

## Verification
A write updates state at the clock edge where the strobe is sampled. A read issued in the following cycle returns that state one edge later, and the illegal pulse is high during the cycle right after the offending access. The bench changes inputs on falling edges and samples outputs on the falling edge right after the edge that registers them. It then checks, one idle cycle later, that the illegal pulse has dropped. Delegation patterns are swept over all 16 combinations of the delegable bits, with four data patterns for each, and the expected values come from a per-bit model written separately from the RTL.

// File: rtl/csr_irq_pkg.sv
package csr_irq_pkg;

  localparam int ADDR_W = 12;

  // interrupt bit positions
  localparam int BIT_SSW  = 1;
  localparam int BIT_MSW  = 3;
  localparam int BIT_STM  = 5;
  localparam int BIT_MTM  = 7;
  localparam int BIT_HOST = 9;
  localparam int BIT_COP  = 10;
  localparam int MIN_XLEN = BIT_COP + 1;

  localparam logic [ADDR_W-1:0] ADR_MPEND    = 12'h344;
  localparam logic [ADDR_W-1:0] ADR_MENAB    = 12'h304;
  localparam logic [ADDR_W-1:0] ADR_DELEG    = 12'h303;
  localparam logic [ADDR_W-1:0] ADR_SPEND    = 12'h144;
  localparam logic [ADDR_W-1:0] ADR_SENAB    = 12'h104;
  localparam logic [ADDR_W-1:0] ADR_STVEC    = 12'h105;
  localparam logic [ADDR_W-1:0] ADR_TOHOST   = 12'h780;
  localparam logic [ADDR_W-1:0] ADR_FROMHOST = 12'h781;
  localparam logic [ADDR_W-1:0] ADR_DOORBELL = 12'h783;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_MPEND,
    SEL_MENAB,
    SEL_DELEG,
    SEL_SPEND,
    SEL_SENAB,
    SEL_STVEC,
    SEL_TOHOST,
    SEL_FROMHOST,
    SEL_DOORBELL
  } csr_sel_e;

  function automatic csr_sel_e addr_to_sel(input logic [ADDR_W-1:0] a);
    csr_sel_e s;
    case (a)
      ADR_MPEND:    s = SEL_MPEND;
      ADR_MENAB:    s = SEL_MENAB;
      ADR_DELEG:    s = SEL_DELEG;
      ADR_SPEND:    s = SEL_SPEND;
      ADR_SENAB:    s = SEL_SENAB;
      ADR_STVEC:    s = SEL_STVEC;
      ADR_TOHOST:   s = SEL_TOHOST;
      ADR_FROMHOST: s = SEL_FROMHOST;
      ADR_DOORBELL: s = SEL_DOORBELL;
      default:      s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/csr_irq_decode.sv
module csr_irq_decode
  import csr_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output csr_sel_e          sel_o,
  output logic              rd_go_o,
  output logic              wr_go_o,
  output logic              bad_o
);

  logic known;

  assign sel_o   = addr_to_sel(addr_i);
  assign known   = (sel_o != SEL_NONE);
  assign rd_go_o = rd_i && known;
  assign wr_go_o = wr_i && known;
  assign bad_o   = (rd_i || wr_i) && !known;

endmodule

// File: rtl/csr_irq_mreg.sv
module csr_irq_mreg #(
  parameter int              W    = 32,
  parameter logic [W-1:0]    IMPL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] wr_allow_i,
  output logic [W-1:0] q_o
);

  // keep bits outside the mask, take bits inside it from the new word
  function automatic logic [W-1:0] merge_bits(input logic [W-1:0] old_v,
                                              input logic [W-1:0] new_v,
                                              input logic [W-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction

  logic [W-1:0] eff_mask;
  assign eff_mask = wr_allow_i & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (wr_en_i) q_o <= merge_bits(q_o, wr_data_i, eff_mask);
  end

  // R11: no write strobe, no change
  assert_hold_when_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(q_o));

  // R2 / R3 / R4: only permitted bits ever move on a write
  assert_mask_respected_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((q_o ^ $past(q_o)) & ~($past(wr_allow_i) & IMPL)) == '0);

endmodule

// File: rtl/csr_irq_host.sv
module csr_irq_host #(
  parameter int XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            to_wr_i,
  input  logic            from_wr_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] tohost_o,
  output logic [XLEN-1:0] fromhost_o,
  output logic            irq_level_o
);

  logic to_empty;
  assign to_empty    = (tohost_o == '0);
  assign irq_level_o = |wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tohost_o   <= '0;
      fromhost_o <= '0;
    end else begin
      if (to_wr_i && to_empty) tohost_o   <= wdata_i;
      if (from_wr_i)           fromhost_o <= wdata_i;
    end
  end

  // R8: an occupied to-host word ignores writes
  assert_tohost_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (to_wr_i && tohost_o != '0) |=> $stable(tohost_o));

  // R9: from-host stores the written value
  assert_fromhost_store_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    from_wr_i |=> fromhost_o == $past(wdata_i));

endmodule

// File: rtl/csr_irq_file.sv
module csr_irq_file
  import csr_irq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] csr_addr_i,
  input  logic [XLEN-1:0]   csr_wdata_i,
  input  logic              csr_we_i,
  input  logic              csr_re_i,
  output logic [XLEN-1:0]   csr_rdata_o,
  output logic              csr_illegal_o
);

  localparam logic [XLEN-1:0] ONE     = {{(XLEN-1){1'b0}}, 1'b1};
  localparam logic [XLEN-1:0] M_SSW   = ONE << BIT_SSW;
  localparam logic [XLEN-1:0] M_MSW   = ONE << BIT_MSW;
  localparam logic [XLEN-1:0] M_STM   = ONE << BIT_STM;
  localparam logic [XLEN-1:0] M_MTM   = ONE << BIT_MTM;
  localparam logic [XLEN-1:0] M_HOST  = ONE << BIT_HOST;
  localparam logic [XLEN-1:0] M_COP   = ONE << BIT_COP;
  localparam logic [XLEN-1:0] DLG_SET = M_SSW | M_STM | M_HOST | M_COP;
  localparam logic [XLEN-1:0] PEND_SW = M_SSW | M_STM | M_MSW;
  localparam logic [XLEN-1:0] ENAB_SW = DLG_SET | M_MSW | M_MTM;
  localparam logic [XLEN-1:0] PEND_IM = PEND_SW | M_HOST;

  // supervisor window: delegated bits that the machine word lets through
  function automatic logic [XLEN-1:0] window_allow(input logic [XLEN-1:0] dlg,
                                                   input logic [XLEN-1:0] machine_mask);
    return dlg & machine_mask;
  endfunction

  function automatic logic [XLEN-1:0] align4(input logic [XLEN-1:0] v);
    return {v[XLEN-1:2], 2'b00};
  endfunction

  // ---------------- decode ----------------
  csr_sel_e sel;
  logic     rd_go, wr_go, bad_acc;

  csr_irq_decode u_dec (
    .addr_i  (csr_addr_i),
    .rd_i    (csr_re_i),
    .wr_i    (csr_we_i),
    .sel_o   (sel),
    .rd_go_o (rd_go),
    .wr_go_o (wr_go),
    .bad_o   (bad_acc)
  );

  // ---------------- named write events ----------------
  logic ev_mpend_wr, ev_spend_wr, ev_menab_wr, ev_senab_wr;
  logic ev_deleg_wr, ev_stvec_wr, ev_to_wr, ev_from_wr, ev_bell_wr;

  assign ev_mpend_wr = wr_go && (sel == SEL_MPEND);
  assign ev_spend_wr = wr_go && (sel == SEL_SPEND);
  assign ev_menab_wr = wr_go && (sel == SEL_MENAB);
  assign ev_senab_wr = wr_go && (sel == SEL_SENAB);
  assign ev_deleg_wr = wr_go && (sel == SEL_DELEG);
  assign ev_stvec_wr = wr_go && (sel == SEL_STVEC);
  assign ev_to_wr    = wr_go && (sel == SEL_TOHOST);
  assign ev_from_wr  = wr_go && (sel == SEL_FROMHOST);
  assign ev_bell_wr  = wr_go && (sel == SEL_DOORBELL);

  // ---------------- state ----------------
  logic [XLEN-1:0] pend_q, enab_q, deleg_q, stvec_q;
  logic [XLEN-1:0] tohost_q, fromhost_q;
  logic            host_level;

  csr_irq_host #(.XLEN(XLEN)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .to_wr_i     (ev_to_wr),
    .from_wr_i   (ev_from_wr),
    .wdata_i     (csr_wdata_i),
    .tohost_o    (tohost_q),
    .fromhost_o  (fromhost_q),
    .irq_level_o (host_level)
  );

  // pending word: four write sources, one per cycle at most
  logic            pend_we;
  logic [XLEN-1:0] pend_wd, pend_allow;

  always_comb begin
    pend_we    = 1'b0;
    pend_wd    = csr_wdata_i;
    pend_allow = '0;
    if (ev_mpend_wr) begin
      pend_we    = 1'b1;
      pend_allow = PEND_SW;
    end else if (ev_spend_wr) begin
      pend_we    = 1'b1;
      pend_allow = window_allow(deleg_q, PEND_SW);
    end else if (ev_bell_wr) begin
      pend_we    = 1'b1;
      pend_wd    = csr_wdata_i[0] ? M_MSW : '0;
      pend_allow = M_MSW;
    end else if (ev_from_wr) begin
      pend_we    = 1'b1;
      pend_wd    = host_level ? M_HOST : '0;
      pend_allow = M_HOST;
    end
  end

  csr_irq_mreg #(.W(XLEN), .IMPL(PEND_IM)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (pend_we),
    .wr_data_i  (pend_wd),
    .wr_allow_i (pend_allow),
    .q_o        (pend_q)
  );

  logic            enab_we;
  logic [XLEN-1:0] enab_allow;

  assign enab_we    = ev_menab_wr || ev_senab_wr;
  assign enab_allow = ev_senab_wr ? window_allow(deleg_q, ENAB_SW) : ENAB_SW;

  csr_irq_mreg #(.W(XLEN), .IMPL(ENAB_SW)) u_enab (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (enab_we),
    .wr_data_i  (csr_wdata_i),
    .wr_allow_i (enab_allow),
    .q_o        (enab_q)
  );

  csr_irq_mreg #(.W(XLEN), .IMPL(DLG_SET)) u_deleg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (ev_deleg_wr),
    .wr_data_i  (csr_wdata_i),
    .wr_allow_i (DLG_SET),
    .q_o        (deleg_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          stvec_q <= '0;
    else if (ev_stvec_wr) stvec_q <= align4(csr_wdata_i);
  end

  // ---------------- read path ----------------
  logic [XLEN-1:0] rd_mux;

  always_comb begin
    case (sel)
      SEL_MPEND:    rd_mux = pend_q;
      SEL_MENAB:    rd_mux = enab_q;
      SEL_DELEG:    rd_mux = deleg_q;
      SEL_SPEND:    rd_mux = pend_q & deleg_q;
      SEL_SENAB:    rd_mux = enab_q & deleg_q;
      SEL_STVEC:    rd_mux = stvec_q;
      SEL_TOHOST:   rd_mux = tohost_q;
      SEL_FROMHOST: rd_mux = fromhost_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csr_rdata_o   <= '0;
      csr_illegal_o <= 1'b0;
    end else begin
      if (rd_go) csr_rdata_o <= rd_mux;
      csr_illegal_o <= bad_acc;
    end
  end

  // ---------------- assertions ----------------
  // R11: bad access gives a pulse on the next cycle, good access does not
  assert_illegal_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_acc |=> csr_illegal_o);
  assert_illegal_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad_acc |=> !csr_illegal_o);
  assert_illegal_no_state_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_acc |=> ($stable(pend_q) && $stable(enab_q) && $stable(deleg_q) &&
                 $stable(stvec_q) && $stable(tohost_q) && $stable(fromhost_q)));

  // R6: a supervisor pending write leaves undelegated bits alone
  assert_spend_keeps_undelegated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_spend_wr |=> ((pend_q ^ $past(pend_q)) & ~$past(deleg_q)) == '0);
  assert_senab_keeps_undelegated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_senab_wr |=> ((enab_q ^ $past(enab_q)) & ~$past(deleg_q)) == '0);

  // R9: host pending bit follows nonzero-ness of the from-host data
  assert_host_bit_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_from_wr |=> pend_q[BIT_HOST] == ($past(csr_wdata_i) != '0));

  // R10: doorbell copies data bit 0 into machine software pending
  assert_doorbell_bit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_bell_wr |=> pend_q[BIT_MSW] == $past(csr_wdata_i[0]));

  // R12: read data holds between decoded reads
  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_go |=> $stable(csr_rdata_o));

  initial begin
    if (XLEN < MIN_XLEN) $error("XLEN too small for interrupt bit layout");
  end

endmodule

// File: tb/csr_irq_file_tb_top.sv
`timescale 1ns/1ps
module csr_irq_file_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        ill;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench-side model of the register contents
  logic [31:0] mp, me, md, stv, th, fh;

  always #2 clk = ~clk;

  csr_irq_file #(.XLEN(32)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .csr_addr_i    (addr),
    .csr_wdata_i   (wdata),
    .csr_we_i      (we),
    .csr_re_i      (re),
    .csr_rdata_o   (rdata),
    .csr_illegal_o (ill)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit known_addr(input logic [11:0] a);
    return a inside {12'h344, 12'h304, 12'h303, 12'h144, 12'h104,
                     12'h105, 12'h780, 12'h781, 12'h783};
  endfunction

  task automatic model_clear();
    mp = '0; me = '0; md = '0; stv = '0; th = '0; fh = '0;
  endtask

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h344: for (int i = 0; i < 32; i++) if (i inside {1, 3, 5}) mp[i] = d[i];
      12'h144: for (int i = 0; i < 32; i++) if ((i inside {1, 3, 5}) && md[i]) mp[i] = d[i];
      12'h304: for (int i = 0; i < 32; i++) if (i inside {1, 3, 5, 7, 9, 10}) me[i] = d[i];
      12'h104: for (int i = 0; i < 32; i++) if ((i inside {1, 3, 5, 7, 9, 10}) && md[i]) me[i] = d[i];
      12'h303: for (int i = 0; i < 32; i++) if (i inside {1, 5, 9, 10}) md[i] = d[i];
      12'h105: stv = d - (d % 4);
      12'h780: if (th == 0) th = d;
      12'h781: begin fh = d; mp[9] = (d != 0); end
      12'h783: mp[3] = d[0];
      default: ;
    endcase
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h344: return mp;
      12'h304: return me;
      12'h303: return md;
      12'h144: return mp & md;
      12'h104: return me & md;
      12'h105: return stv;
      12'h780: return th;
      12'h781: return fh;
      default: return 32'h0;
    endcase
  endfunction

  // write; returns the illegal flag seen in the cycle after
  task automatic wr(input logic [11:0] a, input logic [31:0] d, output logic ill_seen);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    ill_seen = ill;
    model_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v, output logic ill_seen);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    v = rdata;
    ill_seen = ill;
  endtask

  task automatic wr_ok(input string req, input logic [11:0] a, input logic [31:0] d);
    logic il;
    wr(a, d, il);
    chk({req, " no illegal on decoded write"}, {31'b0, il}, 32'h0);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    logic [31:0] v;
    logic il;
    rd(a, v, il);
    chk(req, v, model_read(a));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  localparam logic [11:0] ALL_ADDRS [9] = '{12'h344, 12'h304, 12'h303, 12'h144, 12'h104,
                                           12'h105, 12'h780, 12'h781, 12'h783};

  initial begin
    logic [31:0] v;
    logic        il;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000;
    pats[2] = 32'h5555_5555; pats[3] = 32'hAAAA_AAAA;

    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 illegal low in reset", {31'b0, ill}, 32'h0);
    rst_n = 1'b1;
    foreach (ALL_ADDRS[k]) begin
      rd(ALL_ADDRS[k], v, il);
      chk("R1 reset value", v, 32'h0);
      chk("R1 no illegal", {31'b0, il}, 32'h0);
    end

    // R2: machine pending mask
    wr_ok("R2", 12'h344, 32'hFFFF_FFFF);
    rd_chk("R2 pending mask 0x2A", 12'h344);
    chk("R2 literal", model_read(12'h344), 32'h0000_002A);
    wr_ok("R2", 12'h344, 32'h0);
    rd_chk("R2 pending cleared", 12'h344);

    // R3 / R4: enable and delegation masks
    wr_ok("R3", 12'h304, 32'hFFFF_FFFF);
    rd_chk("R3 enable mask 0x6AA", 12'h304);
    chk("R3 literal", model_read(12'h304), 32'h0000_06AA);
    wr_ok("R4", 12'h303, 32'hFFFF_FFFF);
    rd_chk("R4 delegation mask 0x622", 12'h303);
    chk("R4 literal", model_read(12'h303), 32'h0000_0622);

    // R5 / R6: sweep delegation patterns and data patterns
    for (int d = 0; d < 16; d++) begin
      logic [31:0] dv;
      dv = '0;
      dv[1] = d[0]; dv[5] = d[1]; dv[9] = d[2]; dv[10] = d[3];
      wr_ok("R4", 12'h303, dv | 32'hF000_0000);
      rd_chk("R4 delegation sweep", 12'h303);
      for (int p = 0; p < 4; p++) begin
        wr_ok("R9", 12'h781, {31'b0, p[0]});
        wr_ok("R2", 12'h344, pats[(p + d) % 4]);
        wr_ok("R3", 12'h304, pats[(p + 1 + d) % 4]);
        rd_chk("R5 supervisor pending read", 12'h144);
        rd_chk("R5 supervisor enable read", 12'h104);
        wr_ok("R6", 12'h144, pats[p]);
        rd_chk("R6 machine pending after window write", 12'h344);
        wr_ok("R6", 12'h104, pats[(p + 2) % 4]);
        rd_chk("R6 machine enable after window write", 12'h304);
      end
    end

    // R7: trap vector alignment
    wr_ok("R7", 12'h105, 32'h1234_5677);
    rd_chk("R7 trap vector low bits", 12'h105);
    chk("R7 literal", model_read(12'h105), 32'h1234_5674);
    wr_ok("R7", 12'h105, 32'hFFFF_FFFF);
    rd_chk("R7 trap vector all ones", 12'h105);

    // R9: from-host drives host pending bit; R2: pending write keeps it
    wr_ok("R9", 12'h344, 32'h0);
    wr_ok("R9", 12'h781, 32'h8000_0000);
    rd_chk("R9 from-host value", 12'h781);
    rd_chk("R9 host bit set", 12'h344);
    chk("R9 literal", model_read(12'h344) & 32'h200, 32'h200);
    wr_ok("R2", 12'h344, 32'h0);
    rd_chk("R2 host bit survives pending write", 12'h344);
    wr_ok("R9", 12'h781, 32'h0);
    rd_chk("R9 host bit cleared", 12'h344);

    // R10: doorbell
    wr_ok("R10", 12'h783, 32'h0000_0001);
    rd_chk("R10 doorbell sets bit 3", 12'h344);
    rd(12'h783, v, il);
    chk("R10 doorbell reads zero", v, 32'h0);
    wr_ok("R10", 12'h783, 32'hFFFF_FFFE);
    rd_chk("R10 doorbell clears bit 3", 12'h344);

    // R11: unknown addresses
    foreach (pats[k]) begin
      logic [11:0] bad;
      bad = (k == 0) ? 12'h345 : (k == 1) ? 12'h000 : (k == 2) ? 12'hFFF : 12'h782;
      @(negedge clk);
      addr = bad; wdata = 32'hFFFF_FFFF; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      chk("R11 illegal pulse after bad write", {31'b0, ill}, 32'h1);
      @(negedge clk);
      chk("R11 illegal pulse lasts one cycle", {31'b0, ill}, 32'h0);
      rd(bad, v, il);
      chk("R11 illegal pulse after bad read", {31'b0, il}, 32'h1);
      foreach (ALL_ADDRS[j]) rd_chk("R11 no state change", ALL_ADDRS[j]);
    end

    // R12: read and write in the same cycle
    wr_ok("R12", 12'h304, 32'h0000_0002);
    @(negedge clk);
    addr = 12'h304; wdata = 32'h0000_0080; we = 1'b1; re = 1'b1;
    @(negedge clk);
    we = 1'b0; re = 1'b0;
    chk("R12 read sees old value", rdata, 32'h0000_0002);
    model_write(12'h304, 32'h0000_0080);
    repeat (2) @(negedge clk);
    chk("R12 read data held", rdata, 32'h0000_0002);
    rd_chk("R12 new value visible", 12'h304);

    // R8: to-host accepts only when empty
    wr_ok("R8", 12'h780, 32'h0000_00A5);
    rd_chk("R8 first write taken", 12'h780);
    wr_ok("R8", 12'h780, 32'h0000_003C);
    rd_chk("R8 second write ignored", 12'h780);
    chk("R8 literal", model_read(12'h780), 32'h0000_00A5);
    wr_ok("R8", 12'h780, 32'h0);
    rd_chk("R8 zero write ignored", 12'h780);
    do_reset();
    rd_chk("R1 to-host cleared by reset", 12'h780);
    wr_ok("R8", 12'h780, 32'h0000_003C);
    rd_chk("R8 write after reset taken", 12'h780);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule